// File: doc/BRIEF.md
# Redundant clock failover controller

This block watches two redundant input clocks from a fast, free-running sampling clock. It raises a latched alarm for any input that stops toggling, whether the input is stuck high or stuck low. It also decides which input feeds the downstream clock path. Both inputs are watched all the time. The controller leaves the preferred input only when that input is flagged and the other one is still healthy.

The chosen input is given to a glitch-free output multiplexer in two forms: a registered select and a pair of per-input gate enables. A change of selection always passes through a cycle in which both enables are low, so the multiplexer never forwards a shortened pulse. A manual-override input freezes automatic switching. An alarm-clear pulse re-arms the alarms of inputs that are toggling again. Once the preferred input is clear, the selection returns to it.

Top module: `clk_failover_ctrl`

## Requirements
- R1: Both inputs are monitored continuously. A stalled input sets its own alarm whether or not it is the selected one.
- R2: An input that holds one level, high or low, for `STALL_LIM` sampling cycles after its last synchronised edge sets its alarm. An input still toggling at intervals shorter than that never sets it.
- R3: An alarm (`bad0`, `bad1`) stays high once set. It ignores recovery of the input until `alarm_clr` is pulsed.
- R4: A pulse on `alarm_clr` drops the alarm of every input that is toggling at that moment. An input that is still stalled keeps its alarm high across the pulse.
- R5: With `man_ovr` low, the selection (`sel_stat`: 0 = input 0, 1 = input 1) equals `pri_sel` while that input's alarm is low. It moves to the other input when the preferred input's alarm is high and the other input's alarm is low.
- R6: An alarm on the non-selected input does not change the selection.
- R7: When both alarms are high and `man_ovr` is low, the selection holds its last value.
- R8: While `man_ovr` is high, the selection follows `pri_sel` regardless of the alarms, and the alarms still latch.
- R9: The enables `en0`/`en1` are never both high. A high enable always matches `sel_stat`. `sel_stat` changes only in a cycle after one in which both enables were low.
- R10: During reset both alarms, `sel_stat`, `en0` and `en1` are low. `en0` rises within a few cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, at least 4x the faster monitored clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon0 | input | 1 | Monitored clock input 0 |
| mon1 | input | 1 | Monitored clock input 1 |
| pri_sel | input | 1 | Preferred input (0 or 1) |
| man_ovr | input | 1 | High: selection follows `pri_sel`, no automatic switch |
| alarm_clr | input | 1 | One-cycle pulse that re-arms the alarms |
| bad0 | output | 1 | Latched stall alarm for input 0 |
| bad1 | output | 1 | Latched stall alarm for input 1 |
| sel_stat | output | 1 | Registered select for the output multiplexer |
| en0 | output | 1 | Gate enable for input 0 |
| en1 | output | 1 | Gate enable for input 1 |

## Verification
The bench builds the block with `STALL_LIM` = 10 and two synchroniser stages. The monitored clocks toggle every 3 sampling cycles, so a stall shows up within about a dozen cycles. That short window lets one run walk failover, latching, selective clearing, the double-failure hold and override as a chained state sequence, and it makes the detection window easy to bracket from both sides. A monitor that runs the whole time watches the enables and the select on every cycle, so every handover in the sequence is checked for the low-enable gap.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

  typedef logic [1:0] gate_t;

  // stall decision: the quiet-cycle count reached the limit
  function automatic logic stall_hit(input int unsigned quiet, input int unsigned lim);
    return quiet >= lim;
  endfunction

  // next requested input from preference, override and alarms
  function automatic logic pick_sel(input logic pref, input logic ovr,
                                    input logic bad_pref, input logic bad_alt,
                                    input logic cur);
    if (ovr)           return pref;
    else if (!bad_pref) return pref;
    else if (!bad_alt)  return ~pref;
    else                return cur;
  endfunction

  // gate enable pattern for a selected input
  function automatic gate_t gate_for(input logic s);
    return s ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/cfo_stall_mon.sv
module cfo_stall_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_LIM   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_i,
  input  logic clr_i,
  output logic edge_o,
  output logic stalled_o,
  output logic bad_o
);
  import cfo_pkg::*;

  localparam int CW = $clog2(STALL_LIM + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        quiet_q;
  logic                 bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], mon_i};
  end

  assign edge_o    = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign stalled_o = stall_hit(32'(quiet_q), STALL_LIM);

  // quiet counter: cleared on every edge, saturates at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          quiet_q <= '0;
    else if (edge_o)     quiet_q <= '0;
    else if (!stalled_o) quiet_q <= quiet_q + 1'b1;
  end

  // latched alarm; a clear only drops it when the input is not stalled now
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bad_q <= 1'b0;
    else if (clr_i) bad_q <= stalled_o;
    else            bad_q <= bad_q | stalled_o;
  end

  assign bad_o = bad_q;

  // R3
  bad_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !clr_i) |=> bad_q);

  // R4
  clr_keeps_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && stalled_o) |=> bad_q);

  // R2
  edge_resets_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (quiet_q == '0));

endmodule

// File: rtl/cfo_sel_ctl.sv
module cfo_sel_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_sel,
  input  logic       man_ovr,
  input  logic [1:0] bad_i,
  output logic       sel_req_o
);
  import cfo_pkg::*;

  logic sel_q;
  logic bad_pref, bad_alt;

  assign bad_pref = bad_i[pri_sel];
  assign bad_alt  = bad_i[~pri_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= pick_sel(pri_sel, man_ovr, bad_pref, bad_alt, sel_q);
  end

  assign sel_req_o = sel_q;

  // R8
  ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_ovr |=> (sel_q == $past(pri_sel)));

  // R7
  both_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_ovr && bad_i == 2'b11) |=> $stable(sel_q));

  // R5
  failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_ovr && bad_pref && !bad_alt) |=> (sel_q == ~$past(pri_sel)));

endmodule

// File: rtl/cfo_gate_ctl.sv
module cfo_gate_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_req_i,
  output logic       sel_o,
  output logic [1:0] gate_o
);
  import cfo_pkg::*;

  logic  cur_q, cur_d;
  gate_t gate_q, gate_d;

  // handover: drop enables, then move select, then raise the new enable
  always_comb begin
    cur_d  = cur_q;
    gate_d = gate_for(cur_q);
    if (sel_req_i != cur_q) begin
      gate_d = '0;
      if (gate_q == '0) cur_d = sel_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      gate_q <= '0;
    end else begin
      cur_q  <= cur_d;
      gate_q <= gate_d;
    end
  end

  assign sel_o  = cur_q;
  assign gate_o = gate_q;

  // R9
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_q));

  // R9
  sel_move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != cur_d) |-> (gate_q == '0));

  // R9
  gate_matches_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != '0) |-> gate_q[cur_q]);

endmodule

// File: rtl/clk_failover_ctrl.sv
module clk_failover_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_LIM   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon0,
  input  logic mon1,
  input  logic pri_sel,
  input  logic man_ovr,
  input  logic alarm_clr,
  output logic bad0,
  output logic bad1,
  output logic sel_stat,
  output logic en0,
  output logic en1
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] mon_vec, edge_vec, stall_vec, bad_vec;
  logic              sel_req;
  logic [1:0]        gate;

  assign mon_vec = {mon1, mon0};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_mon
    cfo_stall_mon #(
      .SYNC_STAGES (SYNC_STAGES),
      .STALL_LIM   (STALL_LIM)
    ) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon_i     (mon_vec[i]),
      .clr_i     (alarm_clr),
      .edge_o    (edge_vec[i]),
      .stalled_o (stall_vec[i]),
      .bad_o     (bad_vec[i])
    );
  end

  cfo_sel_ctl u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_sel   (pri_sel),
    .man_ovr   (man_ovr),
    .bad_i     (bad_vec),
    .sel_req_o (sel_req)
  );

  cfo_gate_ctl u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_req_i (sel_req),
    .sel_o     (sel_stat),
    .gate_o    (gate)
  );

  assign bad0 = bad_vec[0];
  assign bad1 = bad_vec[1];
  assign en0  = gate[0];
  assign en1  = gate[1];

  // R1
  edge_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec != '0) |=> ((stall_vec & $past(edge_vec)) == '0));

endmodule

// File: tb/clk_failover_ctrl_tb.sv
`timescale 1ns/1ps
module clk_failover_ctrl_tb;

  localparam int LIM  = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon0 = 1'b0, mon1 = 1'b0;
  logic pri_sel = 1'b0, man_ovr = 1'b0, alarm_clr = 1'b0;
  logic bad0, bad1, sel_stat, en0, en1;

  logic run0 = 1'b1, run1 = 1'b1, park = 1'b0;
  int   ph0 = 0, ph1 = 0;
  int   checks = 0, failures = 0, glitches = 0;
  logic p_sel = 1'b0;
  logic [1:0] p_en = 2'b00;

  always #2.5 clk = ~clk;

  clk_failover_ctrl #(.SYNC_STAGES(2), .STALL_LIM(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .mon0(mon0), .mon1(mon1),
    .pri_sel(pri_sel), .man_ovr(man_ovr), .alarm_clr(alarm_clr),
    .bad0(bad0), .bad1(bad1), .sel_stat(sel_stat), .en0(en0), .en1(en1)
  );

  // monitored clock generators, driven away from the sampling edge
  always @(negedge clk) begin
    if (run0) begin
      if (ph0 == HALF - 1) begin mon0 <= ~mon0; ph0 <= 0; end
      else ph0 <= ph0 + 1;
    end else mon0 <= park;
    if (run1) begin
      if (ph1 == HALF - 1) begin mon1 <= ~mon1; ph1 <= 0; end
      else ph1 <= ph1 + 1;
    end else mon1 <= park;
  end

  // R9 handover monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sel_stat != p_sel && p_en != 2'b00) glitches++;
      if (en0 && en1) glitches++;
      if ((en0 && sel_stat != 1'b0) || (en1 && sel_stat != 1'b1)) glitches++;
    end
    p_sel = sel_stat;
    p_en  = {en1, en0};
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {run0, run1, park, pri, ovr, clr, exp_bad0, exp_bad1, exp_sel}
  localparam logic [8:0] VEC [16] = '{
    9'b110000_000, 9'b110100_001, 9'b110000_000, 9'b011000_101,
    9'b110000_101, 9'b110001_000, 9'b100000_010, 9'b110001_000,
    9'b010000_101, 9'b000000_111, 9'b001001_111, 9'b110001_000,
    9'b010010_100, 9'b010110_101, 9'b110000_101, 9'b110001_000
  };
  localparam string TAG [16] = '{
    "R5", "R5", "R5", "R5 stuck-high failover",
    "R3", "R4", "R1/R6", "R4",
    "R2 stuck-low", "R7", "R4 stalled kept", "R4",
    "R8", "R8", "R5 stay", "R4 return"
  };

  initial begin
    // R10 reset state
    cyc(2);
    chk(!bad0 && !bad1, "R10 alarms", {bad1, bad0}, 0);
    chk(!sel_stat, "R10 sel", sel_stat, 0);
    chk(!en0 && !en1, "R10 enables", {en1, en0}, 0);
    rst_n = 1'b1;
    cyc(4);
    chk(en0 && !en1, "R10 en0 rise", {en1, en0}, 1);

    for (int i = 0; i < 16; i++) begin
      run0 = VEC[i][8]; run1 = VEC[i][7]; park = VEC[i][6];
      pri_sel = VEC[i][5]; man_ovr = VEC[i][4];
      cyc(30);
      if (VEC[i][3]) begin
        alarm_clr = 1'b1; cyc(1); alarm_clr = 1'b0;
      end
      cyc(10);
      chk(bad0 == VEC[i][2], TAG[i], bad0, VEC[i][2]);
      chk(bad1 == VEC[i][1], TAG[i], bad1, VEC[i][1]);
      chk(sel_stat == VEC[i][0], TAG[i], sel_stat, VEC[i][0]);
      chk({en1, en0} == (VEC[i][0] ? 2'b10 : 2'b01), TAG[i], {en1, en0},
          VEC[i][0] ? 2 : 1);
    end

    // R2 detection window: not early, not late
    park = 1'b1; run1 = 1'b0;
    cyc(4);
    chk(!bad1, "R2 early", bad1, 0);
    cyc(LIM + 6);
    chk(bad1, "R2 late", bad1, 1);
    chk(sel_stat == 1'b0, "R6 sel kept", sel_stat, 0);

    // R9 whole-run handover check
    chk(glitches == 0, "R9 handover", glitches, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule